// File: doc/BRIEF.md
# Seven-Pin GPIO Port with Converter and Timer-Clock Overrides

This block is a 7-bit general-purpose I/O port that sits on a small local register bus. Software holds two registers: an output latch, whose value is always presented to the pads, and a direction register, where a 1 turns on a pin's output driver. Each pin's input is passed through a two-flop synchronizer before software can read it.

Two neighbouring modules can take pins away from software. The first is an analog converter. Its 5-bit channel-select value claims pin `i` when the value equals `8 + i`, so channels 8 to 14 map to pins 0 to 6. The second is a timer. When the timer has chosen its external clock source, it claims pin 6. A claimed pin never drives its pad, whatever its direction bit says. The direction bit still decides what a read returns: with the bit set, a read gives the latch. With the bit clear, a read gives 0 on a converter-claimed pin and the synchronized pad on any other pin.

The block holds no sequential state machine. Each pin is decoded every cycle into one of four named modes: `PM_TIMER_CLK`, `PM_ANALOG`, `PM_OUTPUT` and `PM_INPUT`. The decode tries them in that priority order. Only `PM_OUTPUT` enables the pad driver. There are no stored transitions between modes. A pin moves between modes in the same cycle that the direction bit, the channel select or the timer clock select changes.

Top module: `gpio_alt_port`

## Requirements
- R1: A write to offset 0 loads bits 6..0 into the data latch, and `pad_out` shows the new value one cycle later. Bit 7 of any read is always 0.
- R2: Reset does not change the data latch. `pad_out` keeps its value across a reset pulse.
- R3: Reset clears the direction register, so after reset `pad_oe` is 0 and a read at offset 1 returns 0.
- R4: With no converter channel and no timer clock selected, `pad_oe[i]` equals direction bit `i`. A 1 at offset 1 means output.
- R5: A pin whose direction bit is 0 and which the converter has not claimed reads the value of `pad_in` from two clock edges earlier. The value is still the old one after only one edge.
- R6: When `adc_ch == 8+i`, pin `i` has `pad_oe[i]=0`. Its data-read bit is 0 if direction bit `i` is 0, and equals latch bit `i` if direction bit `i` is 1.
- R7: Channel-select values outside 8..14 change neither `pad_oe` nor the read data.
- R8: While `tclk_sel` is 1, `pad_oe[6]` is 0 whatever the direction bit says. The read of bit 6 still follows the direction bit, as in R5 and R6.
- R9: `tmr_ext_clk` equals `pad_in[6]` while `tclk_sel` is 1, and is 0 otherwise.
- R10: Writes need `bus_sel` to be 1. Offset 0 selects the data latch and offset 1 selects the direction register. A write to one register leaves the other unchanged. `bus_rdata` is 0 while `bus_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (qualified by bus_sel) |
| bus_addr | input | 1 | Register offset: 0 data, 1 direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 7 | Pad input values |
| pad_out | output | 7 | Pad output values (data latch) |
| pad_oe | output | 7 | Pad output enables |
| adc_ch | input | 5 | Converter channel select |
| tclk_sel | input | 1 | Timer has chosen the external clock |
| tmr_ext_clk | output | 1 | External clock passed to the timer |

## Verification
On pin 6, the converter claim and the timer-clock claim can be active in the same cycle. This happens when `adc_ch` is 14 and `tclk_sel` is 1. The bench provokes this case by sweeping all 32 channel-select values with `tclk_sel` at both levels and under several direction patterns. For every pin it checks the enable and the read bit against values computed arithmetically from R6 to R8. Both claims must keep the pin from driving, while the read must still follow the converter masking rule.

// File: rtl/gpio_alt_pkg.sv
package gpio_alt_pkg;
    typedef enum logic [1:0] {
        PM_INPUT     = 2'd0,
        PM_OUTPUT    = 2'd1,
        PM_ANALOG    = 2'd2,
        PM_TIMER_CLK = 2'd3
    } pin_mode_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank #(
    parameter int PORT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lat,
    input  logic              wr_dir,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] lat_q,
    output logic [PORT_W-1:0] dir_q
);
    // Output latch: deliberately without reset
    always_ff @(posedge clk) begin
        if (wr_lat) lat_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end
endmodule

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode
    import gpio_alt_pkg::*;
#(
    parameter int PIN_IDX  = 0,
    parameter int CH_W     = 5,
    parameter int CH_BASE  = 8,
    parameter int TCLK_PIN = 6
) (
    input  logic            dir,
    input  logic            lat,
    input  logic            sync_in,
    input  logic [CH_W-1:0] adc_ch,
    input  logic            tclk_sel,
    output pin_mode_e       mode,
    output logic            oe,
    output logic            rd
);
    localparam logic [CH_W-1:0] MY_CH = CH_W'(CH_BASE + PIN_IDX);
    localparam bit IS_TCLK = (PIN_IDX == TCLK_PIN);

    logic adc_hit;
    logic tmr_hit;

    assign adc_hit = (adc_ch == MY_CH);
    assign tmr_hit = IS_TCLK && tclk_sel;

    // Mode decode, priority: timer clock, analog, output, input
    always_comb begin
        if (tmr_hit)      mode = PM_TIMER_CLK;
        else if (adc_hit) mode = PM_ANALOG;
        else if (dir)     mode = PM_OUTPUT;
        else              mode = PM_INPUT;
    end

    // Outputs per mode; read depends on direction bit in every mode
    always_comb begin
        oe = 1'b0;
        rd = 1'b0;
        unique case (mode)
            PM_OUTPUT: begin
                oe = 1'b1;
                rd = lat;
            end
            PM_INPUT: begin
                rd = sync_in;
            end
            PM_ANALOG: begin
                rd = dir ? lat : 1'b0;
            end
            PM_TIMER_CLK: begin
                rd = dir ? lat : (adc_hit ? 1'b0 : sync_in);
            end
            default: begin
                oe = 1'b0;
                rd = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
    import gpio_alt_pkg::*;
#(
    parameter int PORT_W      = 7,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 1,
    parameter int CH_W        = 5,
    parameter int CH_BASE     = 8,
    parameter int TCLK_PIN    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    input  logic [CH_W-1:0]   adc_ch,
    input  logic              tclk_sel,
    output logic              tmr_ext_clk
);
    localparam logic [ADDR_W-1:0] OFF_LAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_DIR = ADDR_W'(1);

    logic [PORT_W-1:0] lat_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] sync_q;
    logic [PORT_W-1:0] rd_vec;
    logic              wr_lat;
    logic              wr_dir;
    pin_mode_e         mode_vec [PORT_W];

    assign wr_lat = bus_sel && bus_wr && (bus_addr == OFF_LAT);
    assign wr_dir = bus_sel && bus_wr && (bus_addr == OFF_DIR);

    gpio_reg_bank #(.PORT_W(PORT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lat (wr_lat),
        .wr_dir (wr_dir),
        .wdata  (bus_wdata[PORT_W-1:0]),
        .lat_q  (lat_q),
        .dir_q  (dir_q)
    );

    gpio_pad_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (sync_q)
    );

    generate
        for (genvar p = 0; p < PORT_W; p++) begin : g_pin
            gpio_pin_mode #(
                .PIN_IDX  (p),
                .CH_W     (CH_W),
                .CH_BASE  (CH_BASE),
                .TCLK_PIN (TCLK_PIN)
            ) u_mode (
                .dir      (dir_q[p]),
                .lat      (lat_q[p]),
                .sync_in  (sync_q[p]),
                .adc_ch   (adc_ch),
                .tclk_sel (tclk_sel),
                .mode     (mode_vec[p]),
                .oe       (pad_oe[p]),
                .rd       (rd_vec[p])
            );

            AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
                pad_oe[p] |-> dir_q[p]); // R4

            AST_ADC_INPUT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_sel && bus_addr == OFF_LAT && adc_ch == CH_W'(CH_BASE + p) && !dir_q[p])
                |-> !bus_rdata[p]); // R6

            AST_ADC_RELEASES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
                (adc_ch == CH_W'(CH_BASE + p)) |-> !pad_oe[p]); // R6
        end
    endgenerate

    assign pad_out     = lat_q;
    assign tmr_ext_clk = tclk_sel & pad_in[TCLK_PIN];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (bus_addr == OFF_LAT)      bus_rdata = DATA_W'(rd_vec);
            else if (bus_addr == OFF_DIR) bus_rdata = DATA_W'(dir_q);
        end
    end

    AST_TCLK_RELEASES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        tclk_sel |-> !pad_oe[TCLK_PIN]); // R8

    AST_LAT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lat |=> (pad_out == $past(bus_wdata[PORT_W-1:0]))); // R1

    AST_DIR_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0)); // R3
endmodule

// File: tb/gpio_alt_port_tb.sv
module gpio_alt_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [0:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] pad_in = '0;
    logic [6:0] pad_out;
    logic [6:0] pad_oe;
    logic [4:0] adc_ch = '0;
    logic       tclk_sel = 1'b0;
    logic       tmr_ext_clk;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_alt_port u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pad_in      (pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .adc_ch      (adc_ch),
        .tclk_sel    (tclk_sel),
        .tmr_ext_clk (tmr_ext_clk)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        bus_read(1'b1, rv);
        check("R3 dir after reset", rv, 8'h00);
        check("R3 oe after reset", {1'b0, pad_oe}, 8'h00);
        bus_read(1'b0, rv);
        check("R10 idle rdata", bus_rdata, 8'h00);

        // R1: latch write, bit 7 reads 0
        bus_write(1'b1, 8'h7F, 1'b1);
        bus_write(1'b0, 8'hFF, 1'b1);
        bus_read(1'b0, rv);
        check("R1 data read", rv, 8'h7F);
        check("R1 pad_out", {1'b0, pad_out}, 8'h7F);
        bus_write(1'b1, 8'hFF, 1'b1);
        bus_read(1'b1, rv);
        check("R1 dir bit7", rv, 8'h7F);

        // R10: unselected write ignored; register isolation
        bus_write(1'b0, 8'h00, 1'b0);
        check("R10 unselected write", {1'b0, pad_out}, 8'h7F);
        bus_write(1'b1, 8'h15, 1'b1);
        bus_read(1'b1, rv);
        check("R10 dir write", rv, 8'h15);
        check("R10 latch untouched", {1'b0, pad_out}, 8'h7F);
        bus_write(1'b0, 8'h2A, 1'b1);
        bus_read(1'b1, rv);
        check("R10 dir untouched", rv, 8'h15);

        // R4: enables follow direction
        check("R4 oe", {1'b0, pad_oe}, 8'h15);

        // R5: synchronizer latency
        bus_write(1'b1, 8'h00, 1'b1);
        pad_in = 7'h00;
        repeat (3) @(negedge clk);
        pad_in = 7'h2C;
        @(posedge clk); #1;
        bus_read(1'b0, rv);
        check("R5 one edge old", rv, 8'h00);
        @(posedge clk); #1;
        bus_read(1'b0, rv);
        check("R5 two edges new", rv, 8'h2C);

        // R2: latch survives reset
        bus_write(1'b0, 8'h4B, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R2 latch kept", {1'b0, pad_out}, 8'h4B);
        bus_read(1'b1, rv);
        check("R3 dir cleared", rv, 8'h00);

        // Sweep R6/R7/R8 over channel select, timer select and directions
        bus_write(1'b0, 8'h5A, 1'b1);
        pad_in = 7'h33;
        repeat (3) @(negedge clk);
        for (int d = 0; d < 4; d++) begin
            logic [6:0] dv;
            dv = (d == 0) ? 7'h00 : (d == 1) ? 7'h7F : (d == 2) ? 7'h55 : 7'h2A;
            bus_write(1'b1, {1'b0, dv}, 1'b1);
            for (int t = 0; t < 2; t++) begin
                for (int c = 0; c < 32; c++) begin
                    logic [6:0] eoe;
                    logic [6:0] erd;
                    @(negedge clk);
                    adc_ch = 5'(c);
                    tclk_sel = (t == 1);
                    for (int i = 0; i < 7; i++) begin
                        logic claim;
                        claim = (c == 8 + i);
                        eoe[i] = dv[i] && !claim && !(i == 6 && t == 1);
                        erd[i] = dv[i] ? 1'(8'h5A >> i) : (claim ? 1'b0 : 1'(8'h33 >> i));
                    end
                    bus_read(1'b0, rv);
                    if (t == 1) begin
                        check("R8 oe timer", {1'b0, pad_oe}, {1'b0, eoe});
                        check("R8 read timer", rv, {1'b0, erd});
                    end else if (c >= 8 && c <= 14) begin
                        check("R6 oe claim", {1'b0, pad_oe}, {1'b0, eoe});
                        check("R6 read claim", rv, {1'b0, erd});
                    end else begin
                        check("R7 oe no claim", {1'b0, pad_oe}, {1'b0, dv});
                        check("R7 read no claim", rv, {1'b0, erd});
                    end
                end
            end
        end

        // R9: timer clock passthrough
        @(negedge clk);
        tclk_sel = 1'b1; pad_in = 7'h40;
        #1 check("R9 clk high", {7'b0, tmr_ext_clk}, 8'h01);
        pad_in = 7'h3F;
        #1 check("R9 clk low", {7'b0, tmr_ext_clk}, 8'h00);
        tclk_sel = 1'b0; pad_in = 7'h40;
        #1 check("R9 deselected", {7'b0, tmr_ext_clk}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule